// File: doc/BRIEF.md
# Per-Core Local Interrupt Unit

This block gathers the interrupt sources that belong to one processor core and presents them through a small word-addressed register window. Four sources are hardware events that arrive as single-cycle pulses: a watchdog expiry, a timer-compare match, a timer tick and a performance-counter overflow. Two more are software interrupts raised by register writes. Each source latches into a pending bit. A separate enable mask gates the pending bit, and a per-source route word steers it to one of the core's interrupt pins, to the non-maskable line and to the auxiliary (YQ) line.

The enable mask is never written directly. One register sets mask bits for every 1 written and another clears them. A control word picks the output mode. In direct mode the pin vector is driven as is. In encoded mode the pin vector is held at zero and a 6-bit number names the highest active pin. Two control bits decide whether the timer and performance-counter sources obey their route words. When such a bit is 0, that source always lands on a fixed default pin.

Top module: `lcl_irq_unit`

## Requirements
- R1: After reset, pending, mask, control and every route word read 0, and pin_o, nmi_o, yq_o and eic_o are 0.
- R2: A 1 on hw_pulse_i[k] (bit 0 watchdog, 1 compare, 2 timer, 3 performance counter) sets pending bit k, which reads back at offset 0x04 from the next cycle. Pending bits 4 and 5 are software interrupts 0 and 1.
- R3: A write to offset 0x14 sets pending bit 4 and/or 5 where the written data has a 1. Data bits 3:0 of that write have no effect.
- R4: A write to offset 0x18 clears each pending bit whose data bit is 1 and leaves the others alone. If a hardware pulse and a clear hit the same bit in the same cycle, the bit stays set.
- R5: Writing 1s to offset 0x10 sets mask bits, and writing 1s to 0x0C clears them, both in the pending bit order. Offset 0x08 returns the mask. Writes to 0x08 and 0x04 have no effect. A source whose mask bit is 0 drives no output.
- R6: The route words sit at 0x40 (watchdog), 0x44 (compare), 0x48 (timer), 0x50 (performance counter), 0x54 (software 0) and 0x58 (software 1). When a source is pending and enabled and bit 31 of its route word is 1, the pin numbered in bits 5:0 is raised. A pin number at or above NUM_PINS raises nothing.
- R7: Route bit 30 sends an active source to nmi_o, and route bit 29 sends it to yq_o.
- R8: Control bit 1 makes the timer routable and control bit 2 makes the performance counter routable. While the bit is 0, that source drives only pin DFLT_PIN (5) and its route word is ignored, including bits 30 and 29.
- R9: With control bit 0 set, pin_o is all zero and eic_o equals one plus the highest active pin index, or 0 when no pin is active. With control bit 0 clear, eic_o is 0.
- R10: A route word reads back with bits 31, 30, 29 and 5:0 as written and all other bits 0. Offsets 0x0C, 0x10, 0x14 and 0x18 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte offset for the write and for the read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| hw_pulse_i | input | 4 | Hardware source event pulses |
| pin_o | output | NUM_PINS | Interrupt pin vector (direct mode) |
| nmi_o | output | 1 | Non-maskable interrupt request |
| yq_o | output | 1 | Auxiliary interrupt request |
| eic_o | output | 6 | Encoded highest active pin + 1 (encoded mode) |

## Verification
A hardware event pulse and a software clear of the pending vector can land on the same bit in the same clock cycle. The bench provokes this by asserting the watchdog pulse together with a 0x18 write that clears bit 0. It expects the pending bit to survive and the watchdog's pin to stay high. In a second case the same clear carries a bit with no coinciding pulse, and the bench expects only that bit to drop. The mask set and clear paths never meet in one cycle because there is a single write port. Their combined effect on the outputs is judged by observing the pins after each single write.

// File: rtl/lcl_irq_pkg.sv
package lcl_irq_pkg;
  localparam int NUM_SRC = 6;
  localparam int NUM_HW  = 4;
  localparam int NUM_SW  = NUM_SRC - NUM_HW;
  localparam int PIN_W   = 6;
  localparam int CTRL_W  = 3;

  localparam int SRC_WD   = 0;
  localparam int SRC_CMP  = 1;
  localparam int SRC_TMR  = 2;
  localparam int SRC_PERF = 3;

  localparam int CTL_EIC     = 0;
  localparam int CTL_TMR_RT  = 1;
  localparam int CTL_PERF_RT = 2;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_PEND  = 8'h04;
  localparam logic [7:0] OFS_MASK  = 8'h08;
  localparam logic [7:0] OFS_MCLR  = 8'h0C;
  localparam logic [7:0] OFS_MSET  = 8'h10;
  localparam logic [7:0] OFS_SWSET = 8'h14;
  localparam logic [7:0] OFS_PCLR  = 8'h18;

  typedef struct packed {
    logic             pin_en;
    logic             nmi_en;
    logic             yq_en;
    logic [PIN_W-1:0] pin;
  } route_t;

  // route words: three at 0x40.., a gap, three at 0x50..
  function automatic logic [7:0] route_ofs(input int idx);
    if (idx < 3) return 8'(8'h40 + 4 * idx);
    else         return 8'(8'h50 + 4 * (idx - 3));
  endfunction
endpackage

// File: rtl/lcl_irq_regs.sv
module lcl_irq_regs
  import lcl_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [31:0]                 wdata_i,
  input  logic [NUM_SRC-1:0]          pend_i,
  output logic [31:0]                 rdata_o,
  output logic [CTRL_W-1:0]           ctrl_o,
  output logic [NUM_SRC-1:0]          mask_o,
  output route_t [NUM_SRC-1:0]        route_o,
  output logic [NUM_SW-1:0]           sw_set_o,
  output logic [NUM_SRC-1:0]          pend_clr_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i[28:PIN_W];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= '0;
      mask_o  <= '0;
      route_o <= '0;
    end else if (wr_i) begin
      if (hit(addr_i, OFS_CTRL)) ctrl_o <= wdata_i[CTRL_W-1:0];
      if (hit(addr_i, OFS_MSET)) mask_o <= mask_o | wdata_i[NUM_SRC-1:0];
      if (hit(addr_i, OFS_MCLR)) mask_o <= mask_o & ~wdata_i[NUM_SRC-1:0];
      for (int i = 0; i < NUM_SRC; i++)
        if (hit(addr_i, route_ofs(i)))
          route_o[i] <= '{pin_en: wdata_i[31], nmi_en: wdata_i[30],
                          yq_en: wdata_i[29], pin: wdata_i[PIN_W-1:0]};
    end
  end

  assign sw_set_o   = (wr_i && hit(addr_i, OFS_SWSET)) ? wdata_i[NUM_SRC-1:NUM_HW] : '0;
  assign pend_clr_o = (wr_i && hit(addr_i, OFS_PCLR))  ? wdata_i[NUM_SRC-1:0]      : '0;

  always_comb begin
    rdata_o = '0;
    if (hit(addr_i, OFS_CTRL)) rdata_o[CTRL_W-1:0]  = ctrl_o;
    if (hit(addr_i, OFS_PEND)) rdata_o[NUM_SRC-1:0] = pend_i;
    if (hit(addr_i, OFS_MASK)) rdata_o[NUM_SRC-1:0] = mask_o;
    for (int i = 0; i < NUM_SRC; i++)
      if (hit(addr_i, route_ofs(i))) begin
        rdata_o[31]         = route_o[i].pin_en;
        rdata_o[30]         = route_o[i].nmi_en;
        rdata_o[29]         = route_o[i].yq_en;
        rdata_o[PIN_W-1:0]  = route_o[i].pin;
      end
  end
endmodule

// File: rtl/lcl_irq_pend.sv
module lcl_irq_pend
  import lcl_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_HW-1:0]  hw_pulse_i,
  input  logic [NUM_SW-1:0]  sw_set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  // a new event beats a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (pend_o & ~clr_i) | {sw_set_i, hw_pulse_i};
  end
endmodule

// File: rtl/lcl_irq_route.sv
module lcl_irq_route
  import lcl_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DFLT_PIN = 5
) (
  input  logic [NUM_SRC-1:0]   pend_i,
  input  logic [NUM_SRC-1:0]   mask_i,
  input  logic [CTRL_W-1:0]    ctrl_i,
  input  route_t [NUM_SRC-1:0] route_i,
  output logic [NUM_PINS-1:0]  pin_o,
  output logic                 nmi_o,
  output logic                 yq_o,
  output logic [PIN_W-1:0]     eic_o
);
  logic [NUM_SRC-1:0]  act;
  logic [NUM_SRC-1:0]  fixed;
  logic [NUM_PINS-1:0] pins;
  logic [PIN_W-1:0]    enc;

  assign act = pend_i & mask_i;

  always_comb begin
    fixed           = '0;
    fixed[SRC_TMR]  = !ctrl_i[CTL_TMR_RT];
    fixed[SRC_PERF] = !ctrl_i[CTL_PERF_RT];
  end

  always_comb begin
    pins  = '0;
    nmi_o = 1'b0;
    yq_o  = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (act[s]) begin
        if (fixed[s]) begin
          pins[DFLT_PIN] = 1'b1;
        end else begin
          for (int p = 0; p < NUM_PINS; p++)
            if (route_i[s].pin_en && route_i[s].pin == PIN_W'(p)) pins[p] = 1'b1;
          nmi_o = nmi_o | route_i[s].nmi_en;
          yq_o  = yq_o  | route_i[s].yq_en;
        end
      end
    end
  end

  // ascending scan: last hit is the highest pin
  always_comb begin
    enc = '0;
    for (int p = 0; p < NUM_PINS; p++)
      if (pins[p]) enc = PIN_W'(p + 1);
  end

  assign pin_o = ctrl_i[CTL_EIC] ? '0  : pins;
  assign eic_o = ctrl_i[CTL_EIC] ? enc : '0;
endmodule

// File: rtl/lcl_irq_unit.sv
module lcl_irq_unit
  import lcl_irq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_PINS = 8,
  parameter int DFLT_PIN = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_HW-1:0]   hw_pulse_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic                nmi_o,
  output logic                yq_o,
  output logic [PIN_W-1:0]    eic_o
);
  logic [CTRL_W-1:0]    ctrl;
  logic [NUM_SRC-1:0]   mask;
  logic [NUM_SRC-1:0]   pend;
  logic [NUM_SRC-1:0]   pend_clr;
  logic [NUM_SW-1:0]    sw_set;
  route_t [NUM_SRC-1:0] routes;

  lcl_irq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .pend_i(pend), .rdata_o, .ctrl_o(ctrl), .mask_o(mask),
    .route_o(routes), .sw_set_o(sw_set), .pend_clr_o(pend_clr)
  );

  lcl_irq_pend u_pend (
    .clk_i, .rst_ni, .hw_pulse_i, .sw_set_i(sw_set),
    .clr_i(pend_clr), .pend_o(pend)
  );

  lcl_irq_route #(.NUM_PINS(NUM_PINS), .DFLT_PIN(DFLT_PIN)) u_route (
    .pend_i(pend), .mask_i(mask), .ctrl_i(ctrl), .route_i(routes),
    .pin_o, .nmi_o, .yq_o, .eic_o
  );
endmodule

// File: rtl/lcl_irq_unit_chk.sv
module lcl_irq_unit_chk
  import lcl_irq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_PINS = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [NUM_SRC-1:0]  wlow_i,
  input logic [NUM_HW-1:0]   hw_pulse_i,
  input logic [NUM_PINS-1:0] pin_o,
  input logic                nmi_o,
  input logic [PIN_W-1:0]    eic_o,
  input logic [NUM_SRC-1:0]  pend_i,
  input logic [NUM_SRC-1:0]  mask_i,
  input logic                eic_mode_i
);
  a_r2_pulse_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_pulse_i != '0) |=> ((pend_i[NUM_HW-1:0] & $past(hw_pulse_i)) == $past(hw_pulse_i)));

  a_r4_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(OFS_PCLR) && hw_pulse_i == '0) |=> ((pend_i & $past(wlow_i)) == '0));

  a_r5_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(OFS_MSET)) |=> ((mask_i & $past(wlow_i)) == $past(wlow_i)));

  a_r5_mask_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(OFS_MCLR)) |=> ((mask_i & $past(wlow_i)) == '0));

  a_r9_eic_pins_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eic_mode_i |-> (pin_o == '0));

  a_r9_eic_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eic_mode_i |-> (eic_o == '0));

  a_r7_nmi_needs_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> ((pend_i & mask_i) != '0));
endmodule

bind lcl_irq_unit lcl_irq_unit_chk #(.ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
  .wlow_i(wdata_i[5:0]), .hw_pulse_i(hw_pulse_i), .pin_o(pin_o),
  .nmi_o(nmi_o), .eic_o(eic_o), .pend_i(pend), .mask_i(mask),
  .eic_mode_i(ctrl[0])
);

// File: tb/tb_lcl_irq_unit.sv
module tb_lcl_irq_unit;
  localparam int ADDR_W   = 8;
  localparam int NUM_PINS = 8;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                wr = 1'b0;
  logic [ADDR_W-1:0]   addr = '0;
  logic [31:0]         wdata = '0;
  logic [31:0]         rdata;
  logic [3:0]          pulse = '0;
  logic [NUM_PINS-1:0] pins;
  logic                nmi, yq;
  logic [5:0]          eic;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lcl_irq_unit #(.ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .hw_pulse_i(pulse), .pin_o(pins), .nmi_o(nmi),
    .yq_o(yq), .eic_o(eic)
  );

  // sel: 0 rdata, 1 pins, 2 nmi, 3 yq, 4 eic
  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always @(negedge clk) begin
    if (sb.size() != 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.sel)
        0:       act = rdata;
        1:       act = 32'(pins);
        2:       act = 32'(nmi);
        3:       act = 32'(yq);
        default: act = 32'(eic);
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
      end
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr = 1'b0; wdata = '0;
  endtask

  task automatic hit(input logic [3:0] v);
    @(posedge clk); #1;
    pulse = v;
    @(posedge clk); #1;
    pulse = '0;
  endtask

  task automatic wr_hit(input logic [7:0] a, input logic [31:0] d, input logic [3:0] v);
    @(posedge clk); #1;
    wr = 1'b1; addr = a; wdata = d; pulse = v;
    @(posedge clk); #1;
    wr = 1'b0; wdata = '0; pulse = '0;
  endtask

  task automatic expect_item(input int sel, input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    addr = a;
    it.sel = sel; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    expect_item(0, 8'h04, 32'h0, "R1 pending");
    expect_item(0, 8'h08, 32'h0, "R1 mask");
    expect_item(0, 8'h00, 32'h0, "R1 ctrl");
    expect_item(0, 8'h58, 32'h0, "R1 route");
    expect_item(1, 8'h00, 32'h0, "R1 pins");
    expect_item(2, 8'h00, 32'h0, "R1 nmi");
    expect_item(4, 8'h00, 32'h0, "R1 eic");

    // R10 route readback, masked fields
    wr_reg(8'h40, 32'hE000_FF03);
    expect_item(0, 8'h40, 32'hE000_0003, "R10 route readback");
    wr_reg(8'h10, 32'h0000_0001);
    expect_item(0, 8'h10, 32'h0, "R10 set-mask reads 0");
    expect_item(0, 8'h0C, 32'h0, "R10 clear-mask reads 0");

    // R5 mask set/clear, direct write ignored
    wr_reg(8'h10, 32'h0000_003F);
    expect_item(0, 8'h08, 32'h3F, "R5 set all");
    wr_reg(8'h0C, 32'h0000_0005);
    expect_item(0, 8'h08, 32'h3A, "R5 clear 0,2");
    wr_reg(8'h08, 32'h0);
    expect_item(0, 8'h08, 32'h3A, "R5 direct write ignored");
    wr_reg(8'h04, 32'h3F);
    expect_item(0, 8'h04, 32'h0, "R5 pending write ignored");
    wr_reg(8'h10, 32'h0000_003F);

    // R2 watchdog pulse, R6/R7 routing
    hit(4'b0001);
    expect_item(0, 8'h04, 32'h01, "R2 watchdog latched");
    expect_item(1, 8'h00, 32'h08, "R6 pin 3");
    expect_item(2, 8'h00, 32'h1, "R7 nmi");
    expect_item(3, 8'h00, 32'h1, "R7 yq");

    // R4 clear
    wr_reg(8'h18, 32'h01);
    expect_item(0, 8'h04, 32'h0, "R4 cleared");
    expect_item(1, 8'h00, 32'h0, "R4 pins drop");
    expect_item(2, 8'h00, 32'h0, "R4 nmi drops");

    // R3 software set, low bits ignored
    wr_reg(8'h14, 32'h3F);
    expect_item(0, 8'h04, 32'h30, "R3 sw set only");
    wr_reg(8'h54, 32'h8000_0002);
    expect_item(1, 8'h00, 32'h04, "R3 sw0 to pin 2");
    wr_reg(8'h18, 32'h30);
    expect_item(0, 8'h04, 32'h0, "R4 sw cleared");

    // R8 timer routability
    hit(4'b0100);
    wr_reg(8'h48, 32'hC000_0001);
    expect_item(1, 8'h00, 32'h20, "R8 timer default pin");
    expect_item(2, 8'h00, 32'h0, "R8 timer route ignored");
    wr_reg(8'h00, 32'h2);
    expect_item(1, 8'h00, 32'h02, "R8 timer routed");
    expect_item(2, 8'h00, 32'h1, "R8 timer nmi");
    wr_reg(8'h18, 32'h04);

    // R8 perf routability
    hit(4'b1000);
    wr_reg(8'h50, 32'h8000_0000);
    expect_item(1, 8'h00, 32'h20, "R8 perf default pin");
    wr_reg(8'h00, 32'h6);
    expect_item(1, 8'h00, 32'h01, "R8 perf routed");

    // R6 out-of-range and disabled pin
    hit(4'b0010);
    wr_reg(8'h44, 32'h8000_0009);
    expect_item(1, 8'h00, 32'h01, "R6 pin beyond range");
    wr_reg(8'h44, 32'h0000_0002);
    expect_item(1, 8'h00, 32'h01, "R6 pin enable off");
    wr_reg(8'h44, 32'h8000_0006);
    expect_item(1, 8'h00, 32'h41, "R6 pin 6");

    // R9 encoded mode
    wr_reg(8'h00, 32'h7);
    expect_item(1, 8'h00, 32'h0, "R9 pins quiet");
    expect_item(4, 8'h00, 32'h7, "R9 highest pin 6");
    wr_reg(8'h18, 32'h02);
    expect_item(4, 8'h00, 32'h1, "R9 pin 0");
    wr_reg(8'h18, 32'h08);
    expect_item(4, 8'h00, 32'h0, "R9 none");
    wr_reg(8'h00, 32'h0);
    expect_item(4, 8'h00, 32'h0, "R9 direct mode");

    // R4 collision: pulse and clear on the same bit
    hit(4'b0010);
    wr_hit(8'h18, 32'h03, 4'b0001);
    expect_item(0, 8'h04, 32'h01, "R4 pulse beats clear");
    expect_item(1, 8'h00, 32'h08, "R4 pin stays");

    // R5 mask gates output
    wr_reg(8'h0C, 32'h01);
    expect_item(1, 8'h00, 32'h0, "R5 masked pin");
    expect_item(2, 8'h00, 32'h0, "R5 masked nmi");
    expect_item(0, 8'h04, 32'h01, "R5 pending kept");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule